// File: doc/BRIEF.md
# Single-Point Chromosome Crossover Stage

This block performs single-point recombination for a hardware genetic-algorithm pipeline. Two parent chromosomes and a cut position arrive together, qualified by a valid strobe. The cut position is decoded into a fixed-width thermometer mask. Every bit at or below the cut comes from one parent, and every bit above it comes from the other. The two offspring use the parents in opposite roles, so between them they hold every bit of both parents.

The cut position is driven from outside the block, usually by a pseudo-random source. Both offspring and the valid flag are registered, so a result appears one clock after its inputs are accepted. Selection uses a mask and never a slice whose width depends on the input, so the datapath is purely combinational logic feeding flip-flops, and no latches form.

Top module: `xover_unit`

## Requirements
- R1: Parents and offspring are `GENE_W` bits wide (default 64). The cut position is an unsigned `$clog2(GENE_W)`-bit value (default 6).
- R2: Mask bit k is 1 when k <= cut and 0 otherwise.
- R3: `kid_a` = (mask & `par_a`) | (~mask & `par_b`).
- R4: `kid_b` = (mask & `par_b`) | (~mask & `par_a`).
- R5: With cut = 7, `par_a` all ones and `par_b` all zeros, `kid_a` is 0x00000000000000FF and `kid_b` is its bitwise complement.
- R6: With cut = 63 the mask is all ones, so `kid_a` equals `par_a` and `kid_b` equals `par_b`.
- R7: With cut = 0 only bit 0 of `kid_a` comes from `par_a`, and only bit 0 of `kid_b` comes from `par_b`.
- R8: Inputs are sampled on a rising edge with `in_vld` high. The offspring and `out_vld` = 1 are visible after that edge. An edge with `in_vld` low drives `out_vld` to 0 and leaves both offspring unchanged.
- R9: A synchronous active-high `rst` clears `out_vld`, `kid_a` and `kid_b` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifies parents and cut position |
| par_a | input | 64 | First parent chromosome |
| par_b | input | 64 | Second parent chromosome |
| cut | input | 6 | Crossover position, unsigned |
| out_vld | output | 1 | Offspring registers hold a fresh result |
| kid_a | output | 64 | Low part from par_a, high part from par_b |
| kid_b | output | 64 | Low part from par_b, high part from par_a |

## Verification
A wrong mask decode, such as an off-by-one boundary or a flipped comparison, shows in the offspring one clock after the affected cut value is accepted. Complementary parent patterns expose every misplaced bit at that point. Swapped parent roles show on the first accepted sample whose parents differ. A capture-enable fault shows as offspring that change, or a valid flag that stays high, on the cycle after an idle edge.

// File: rtl/xover_pkg.sv
package xover_pkg;
    localparam int GENE_W = 64;
    localparam int CUT_W  = $clog2(GENE_W);

    typedef logic [GENE_W-1:0] gene_t;

    typedef struct packed {
        gene_t hi_lo_a;
        gene_t hi_lo_b;
    } brood_t;
endpackage

// File: rtl/xover_mask.sv
module xover_mask #(
    parameter int W  = 64,
    parameter int CW = $clog2(W)
) (
    input  logic [CW-1:0] cut,
    output logic [W-1:0]  mask
);
    for (genvar k = 0; k < W; k++) begin : g_therm
        assign mask[k] = (CW'(k) <= cut);
    end

    always_comb begin
        // R2: bit 0 always set; set bits form a contiguous low run of cut+1
        assert (mask[0] == 1'b1);
        assert ($countones(mask) == int'(cut) + 1);
    end
endmodule

// File: rtl/xover_mix.sv
module xover_mix #(
    parameter int W = 64
) (
    input  logic [W-1:0] mask,
    input  logic [W-1:0] p_lo,
    input  logic [W-1:0] p_hi,
    output logic [W-1:0] kid
);
    assign kid = (mask & p_lo) | (~mask & p_hi);
endmodule

// File: rtl/xover_unit.sv
module xover_unit
    import xover_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [GENE_W-1:0] par_a,
    input  logic [GENE_W-1:0] par_b,
    input  logic [CUT_W-1:0]  cut,
    output logic             out_vld,
    output logic [GENE_W-1:0] kid_a,
    output logic [GENE_W-1:0] kid_b
);
    gene_t  mask;
    brood_t nxt, cur;
    logic   vld_q;

    xover_mask #(.W(GENE_W), .CW(CUT_W)) u_mask (.cut(cut), .mask(mask));

    // R3 / R4: one mixer per offspring, parents in opposite roles
    for (genvar i = 0; i < 2; i++) begin : g_mix
        if (i == 0) begin : g_a
            xover_mix #(.W(GENE_W)) u_mix (.mask(mask), .p_lo(par_a), .p_hi(par_b), .kid(nxt.hi_lo_a));
        end else begin : g_b
            xover_mix #(.W(GENE_W)) u_mix (.mask(mask), .p_lo(par_b), .p_hi(par_a), .kid(nxt.hi_lo_b));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) cur <= nxt;
        end
    end

    assign out_vld = vld_q;
    assign kid_a   = cur.hi_lo_a;
    assign kid_b   = cur.hi_lo_b;

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_vld && kid_a == '0 && kid_b == '0));

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(kid_a) && $stable(kid_b) && !out_vld));

    assert_bits_conserved_R4: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> ((kid_a ^ kid_b) == ($past(par_a) ^ $past(par_b))));

    assert_full_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && cut == '1) |=> (kid_a == $past(par_a) && kid_b == $past(par_b)));
endmodule

// File: tb/sim_xover_unit.sv
module sim_xover_unit;
    localparam int TCLK = 10;
    localparam int W = 64;

    logic clk = 0, rst = 1, in_vld = 0;
    logic [W-1:0] par_a = '0, par_b = '0;
    logic [5:0] cut = '0;
    logic out_vld;
    logic [W-1:0] kid_a, kid_b;
    int n_chk = 0, n_bad = 0;

    always #(TCLK/2) clk = ~clk;

    xover_unit u0 (.clk, .rst, .in_vld, .par_a, .par_b, .cut, .out_vld, .kid_a, .kid_b);

    function automatic logic [W-1:0] ref_mask(input int c);
        logic [W-1:0] m = '0;
        for (int k = 0; k < W; k++) if (k <= c) m[k] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input int c, input string req);
        logic [W-1:0] m = ref_mask(c);
        @(negedge clk);
        par_a = a; par_b = b; cut = 6'(c); in_vld = 1;
        @(negedge clk);
        in_vld = 0;
        chk({req, " vld"}, W'(out_vld), W'(1));
        chk({req, " kid_a"}, kid_a, (m & a) | (~m & b));
        chk({req, " kid_b"}, kid_b, (m & b) | (~m & a));
    endtask

    initial begin
        #(TCLK*20000);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] ha, hb;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R9 reset vld", W'(out_vld), W'(0));
        chk("R9 reset kid_a", kid_a, '0);
        chk("R9 reset kid_b", kid_b, '0);

        // R5 directed
        apply('1, '0, 7, "R5");
        chk("R5 literal", kid_a, 64'h00000000000000FF);
        chk("R5 complement", kid_b, ~64'h00000000000000FF);
        // R6
        apply(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 63, "R6");
        chk("R6 a", kid_a, 64'h0123456789ABCDEF);
        // R7
        apply('1, '0, 0, "R7");
        chk("R7 literal", kid_a, 64'h1);
        // R2 sweep every cut with complementary parents
        for (int c = 0; c < 64; c++) apply('0, '1, c, "R2");

        // R8 idle hold
        ha = kid_a; hb = kid_b;
        @(negedge clk); par_a = '1; par_b = 64'h5555; cut = 6'd30;
        @(negedge clk);
        chk("R8 idle vld", W'(out_vld), W'(0));
        chk("R8 idle kid_a", kid_a, ha);
        chk("R8 idle kid_b", kid_b, hb);

        // R1 R3 R4 random
        for (int i = 0; i < 200; i++)
            apply({$urandom, $urandom}, {$urandom, $urandom}, int'($urandom % 64), "R3R4 R1");

        // R9 mid-run reset
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R9 rerst vld", W'(out_vld), W'(0));
        chk("R9 rerst kid_a", kid_a, '0);
        chk("R9 rerst kid_b", kid_b, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule